// File: doc/BRIEF.md
# Flow-Through Byte-Lane Static RAM Core

This block is a synchronous static memory with nine-bit byte lanes. On each rising clock edge it captures a chip select, an address, write data and three write controls: an all-lanes write, a write enable and one enable per lane. The captured address selects the word that drives the read port in the cycle that follows. No output register sits in that path, so read data is valid within the same cycle the address was captured. A write uses that same captured cycle: the selected lanes are committed into the array on the next rising edge. No outside write strobe is needed.

The read port is shown as a data bus with a separate drive flag. A low drive flag stands for high impedance, and the data bus is then zero. The drive flag follows the asynchronous output enable without any clock. Deselecting the core releases the bus in the very next cycle. The asynchronous reset clears the control registers. Its release is synchronised to the clock inside the block. The array contents are not reset.

Top module: `fts_core`

## Requirements
- R1: Lane k occupies data bits [9k+8:9k] and is written only through lane enable bit k. With the write enable set and only lane_en bit 0 set, bits [8:0] change and all other bits keep their old value.
- R2: With all_wr low, a selected cycle writes exactly the lanes whose lane_en bits are set, and only when wr_en is high.
- R3: A selected cycle with all_wr high writes every lane, whatever wr_en and lane_en hold.
- R4: A selected cycle with wr_en high and every lane_en bit high writes every lane.
- R5: A selected cycle with all_wr low and wr_en low writes nothing, even if lane enables are set. It is a read cycle.
- R6: In a selected read cycle with oe high, rd_data equals the word at the address captured at the edge that opened that cycle, before the next edge.
- R7: oe acts without a clock. While oe is low, rd_drive is low. Raising oe inside a read cycle raises rd_drive without any clock edge.
- R8: If sel is low at an edge, rd_drive is low for the whole following cycle. A select at the next edge drives data again at once.
- R9: rd_drive is low during any cycle in which at least one lane is being written.
- R10: A read of an address in the cycle right after a write to it returns the old word with the written lanes replaced.
- R11: After reset and before any selected cycle, rd_drive is low even with oe high.
- R12: A cycle captured with sel low writes nothing, whatever the write controls hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Chip select, captured on the edge |
| addr | input | ADDR_W | Word address, captured when selected |
| all_wr | input | 1 | Write every lane, captured |
| wr_en | input | 1 | Write enable for the lane enables, captured |
| lane_en | input | LANES | Per-lane write enables, captured |
| wr_data | input | 9*LANES | Write data, captured when selected |
| oe | input | 1 | Asynchronous output enable |
| rd_data | output | 9*LANES | Read word, zero while not driven |
| rd_drive | output | 1 | High when the read bus is driven, low for high impedance |

## Verification
A lane commit from a write cycle and the flow-through read of the next cycle reach the same array word at the same clock edge. The commit is the one that turns the write into stored state, and the read shows that state combinationally. The bench provokes this for every address and for all sixteen combinations of the write controls. Each write is followed at once by a read of the same address. The value read is compared with a bench model that merges the lanes as R1 to R5 prescribe. The asynchronous output enable is also toggled between edges inside a read cycle, where it is the only thing that can change the drive flag.

// File: rtl/fts_pkg.sv
package fts_pkg;
  localparam int unsigned LANE_BITS = 9;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_kind_e;
endpackage

// File: rtl/fts_in_reg.sv
module fts_in_reg
  import fts_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 2,
  localparam int unsigned DW    = LANES * LANE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              all_wr,
  input  logic              wr_en,
  input  logic [LANES-1:0]  lane_en,
  input  logic [DW-1:0]     wr_data,
  output logic              sel_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              all_q,
  output logic              wen_q,
  output logic [LANES-1:0]  len_q,
  output logic [DW-1:0]     wdat_q
);
  logic             all_d, wen_d;
  logic [LANES-1:0] len_d;
  logic             cap_en;

  // Write controls only matter while selected; clear them otherwise.
  always_comb begin
    cap_en = sel;
    all_d  = sel & all_wr;
    wen_d  = sel & wr_en;
    len_d  = sel ? lane_en : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      all_q <= 1'b0;
      wen_q <= 1'b0;
      len_q <= '0;
    end else begin
      sel_q <= sel;
      all_q <= all_d;
      wen_q <= wen_d;
      len_q <= len_d;
    end
  end

  // Data-path registers: no reset, loaded only when selected.
  always_ff @(posedge clk) begin
    if (cap_en) begin
      addr_q <= addr;
      wdat_q <= wr_data;
    end
  end
endmodule

// File: rtl/fts_lane_dec.sv
module fts_lane_dec
  import fts_pkg::*;
#(
  parameter int unsigned LANES = 2
) (
  input  logic             sel_q,
  input  logic             all_q,
  input  logic             wen_q,
  input  logic [LANES-1:0] len_q,
  output logic [LANES-1:0] lane_wr,
  output cyc_kind_e        kind
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_wr[g] = sel_q & (all_q | (wen_q & len_q[g]));
  end

  always_comb begin
    if (|lane_wr)   kind = CYC_WRITE;
    else if (sel_q) kind = CYC_READ;
    else            kind = CYC_IDLE;
  end
endmodule

// File: rtl/fts_array.sv
module fts_array
  import fts_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 2,
  localparam int unsigned DW    = LANES * LANE_BITS,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic [LANES-1:0]  lane_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wdat,
  output logic [DW-1:0]     rdat
);
  for (genvar g = 0; g < LANES; g++) begin : g_bank
    logic [LANE_BITS-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (lane_wr[g]) mem[addr] <= wdat[g*LANE_BITS +: LANE_BITS];
    end

    assign rdat[g*LANE_BITS +: LANE_BITS] = mem[addr];
  end
endmodule

// File: rtl/fts_core.sv
module fts_core
  import fts_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 2,
  localparam int unsigned DW    = LANES * LANE_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              all_wr,
  input  logic              wr_en,
  input  logic [LANES-1:0]  lane_en,
  input  logic [DW-1:0]     wr_data,
  input  logic              oe,
  output logic [DW-1:0]     rd_data,
  output logic              rd_drive
);
  logic [1:0]        rst_sync;
  logic              rst_core_n;
  logic              sel_q, all_q, wen_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0]  len_q, lane_wr;
  logic [DW-1:0]     wdat_q, arr_rd;
  cyc_kind_e         kind;

  // Reset: asserted asynchronously, released on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  fts_in_reg #(.ADDR_W(ADDR_W), .LANES(LANES)) u_in (
    .clk(clk), .rst_n(rst_core_n), .sel(sel), .addr(addr),
    .all_wr(all_wr), .wr_en(wr_en), .lane_en(lane_en), .wr_data(wr_data),
    .sel_q(sel_q), .addr_q(addr_q), .all_q(all_q), .wen_q(wen_q),
    .len_q(len_q), .wdat_q(wdat_q)
  );

  fts_lane_dec #(.LANES(LANES)) u_dec (
    .sel_q(sel_q), .all_q(all_q), .wen_q(wen_q), .len_q(len_q),
    .lane_wr(lane_wr), .kind(kind)
  );

  fts_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_arr (
    .clk(clk), .lane_wr(lane_wr), .addr(addr_q), .wdat(wdat_q), .rdat(arr_rd)
  );

  // Flow-through output, gated asynchronously by oe.
  assign rd_drive = oe & (kind == CYC_READ);
  assign rd_data  = rd_drive ? arr_rd : '0;
endmodule

// File: rtl/fts_core_chk.sv
module fts_core_chk #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 2,
  localparam int unsigned DW    = LANES * 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              oe,
  input logic              rd_drive,
  input logic [DW-1:0]     rd_data,
  input logic              sel_q,
  input logic              all_q,
  input logic              wen_q,
  input logic [ADDR_W-1:0] addr_q,
  input logic [DW-1:0]     wdat_q,
  input logic [LANES-1:0]  lane_wr
);
  // R7
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !oe |-> !rd_drive);

  // R9
  wr_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|lane_wr) |-> !rd_drive);

  // R8
  desel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_q |-> !rd_drive);

  // R3
  all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q && all_q) |-> (lane_wr == {LANES{1'b1}}));

  // R5
  no_wen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!all_q && !wen_q) |-> (lane_wr == '0));

  // R10
  raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_drive && $past(sel_q && all_q) && addr_q == $past(addr_q))
      |-> rd_data == $past(wdat_q));
endmodule

bind fts_core fts_core_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_core_n), .oe(oe), .rd_drive(rd_drive),
  .rd_data(rd_data), .sel_q(sel_q), .all_q(all_q), .wen_q(wen_q),
  .addr_q(addr_q), .wdat_q(wdat_q), .lane_wr(lane_wr)
);

// File: tb/sim_fts_core.sv
module sim_fts_core;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int NL = 2;
  localparam int DW = NL * 9;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          sel, all_wr, wr_en, oe;
  logic [AW-1:0] addr;
  logic [NL-1:0] lane_en;
  logic [DW-1:0] wr_data, rd_data;
  logic          rd_drive;
  logic [DW-1:0] model [DEPTH];
  int            n_chk = 0;
  int            n_fail = 0;
  bit            done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fts_core #(.ADDR_W(AW), .LANES(NL)) u0 (
    .clk(clk), .rst_n(rst_n), .sel(sel), .addr(addr), .all_wr(all_wr),
    .wr_en(wr_en), .lane_en(lane_en), .wr_data(wr_data), .oe(oe),
    .rd_data(rd_data), .rd_drive(rd_drive)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // Called at a falling edge; returns at the falling edge of the captured cycle.
  task automatic cyc(input logic s, input logic [AW-1:0] a, input logic g,
                     input logic w, input logic [NL-1:0] b, input logic [DW-1:0] d);
    sel = s; addr = a; all_wr = g; wr_en = w; lane_en = b; wr_data = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old,
      input logic [DW-1:0] nw, input logic [NL-1:0] m);
    logic [DW-1:0] r = old;
    for (int i = 0; i < NL; i++) if (m[i]) r[i*9 +: 9] = nw[i*9 +: 9];
    return r;
  endfunction

  function automatic logic [DW-1:0] pat(input int a, input int c, input int k);
    logic [31:0] t = 32'(a * 7919 + c * 2749 + k * 613 + 12345);
    return t[DW-1:0];
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sel = 0; addr = '0; all_wr = 0; wr_en = 0;
    lane_en = '0; wr_data = '0; oe = 1'b1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11: idle after reset, no drive with oe high
    chk("R11 drive", 32'(rd_drive), 0);
    chk("R11 data", 32'(rd_data), 0);

    // Fill every word with an all-lanes write (R3), each a hi-Z cycle (R9)
    for (int a = 0; a < DEPTH; a++) begin
      model[a] = pat(a, 99, 1);
      cyc(1, AW'(a), 1, 0, '0, model[a]);
      chk("R9 fill", 32'(rd_drive), 0);
    end

    // Sweep all write-control combinations on every address
    for (int a = 0; a < DEPTH; a++) begin
      for (int c = 0; c < 16; c++) begin
        logic g = c[3];
        logic w = c[2];
        logic [NL-1:0] b = c[1:0];
        logic [NL-1:0] m = g ? '1 : (w ? b : '0);
        logic [DW-1:0] d = pat(a, c, 2);
        string tag;
        if (g)               tag = "R3";
        else if (!w)         tag = "R5";
        else if (b == 2'b11) tag = "R4";
        else if (b == 2'b01) tag = "R1";
        else                 tag = "R2";
        cyc(1, AW'(a), g, w, b, d);
        if (m != '0) begin
          chk("R9 write hiz", 32'(rd_drive), 0);
        end else begin
          chk("R6 read in cycle", 32'(rd_drive), 1);
          chk("R6 data", 32'(rd_data), 32'(model[a]));
        end
        model[a] = merge(model[a], d, m);
        cyc(1, AW'(a), 0, 0, '0, '0);
        chk({tag, " R10 merged"}, 32'(rd_data), 32'(model[a]));
      end
    end

    // R8: deselect releases the bus next cycle, reselect reads at once
    cyc(1, 6'd5, 0, 0, '0, '0);
    chk("R8 before", 32'(rd_drive), 1);
    cyc(0, 6'd5, 0, 0, '0, '0);
    chk("R8 desel drive", 32'(rd_drive), 0);
    chk("R8 desel data", 32'(rd_data), 0);
    cyc(1, 6'd9, 0, 0, '0, '0);
    chk("R8 reselect", 32'(rd_drive), 1);
    chk("R8 reselect data", 32'(rd_data), 32'(model[9]));

    // R12: writes with sel low are ignored
    cyc(0, 6'd9, 1, 1, 2'b11, ~model[9]);
    cyc(1, 6'd9, 0, 0, '0, '0);
    chk("R12 unchanged", 32'(rd_data), 32'(model[9]));

    // R7: oe toggled between edges in a read cycle
    #1 oe = 1'b0;
    #1 chk("R7 oe low", 32'(rd_drive), 0);
    chk("R7 oe low data", 32'(rd_data), 0);
    oe = 1'b1;
    #1 chk("R7 oe high", 32'(rd_drive), 1);
    chk("R7 oe high data", 32'(rd_data), 32'(model[9]));

    // R6: back-to-back reads walk the whole array
    @(negedge clk);
    for (int a = 0; a < DEPTH; a++) begin
      cyc(1, AW'(a), 0, 0, '0, '0);
      chk("R6 walk", 32'(rd_data), 32'(model[a]));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule